// File: doc/BRIEF.md
# H-Bridge Gate Guard

This block is the digital control core of one H-bridge. The bridge has two output legs, and each leg has a high-side and a low-side switch. Each of the four switches has its own command input. No direction or PWM decoding takes place. The block filters each command and refuses any request that would turn on both switches of one leg. It keeps both switches of a leg off for a fixed dead interval before either one turns on. Its outputs are four gate enables.

The block also enforces the shutdown rules for four kinds of fault. Each fault recovers in its own way:

- Overcurrent: the block retries on a timer.
- Over-temperature: the block waits for a separate "cooled down" flag.
- Undervoltage: the block clears all of its control state.
- Overvoltage: the block releases the outputs as soon as the flag drops.

While the sleep input is low, every switch is off and the control state is held cleared. A 3-bit status output names the highest-priority active fault.

After any shutdown ends, no gate turns on until two things have happened. First, the commands are filtered again from a cleared state. Second, the full dead interval has passed. The analog comparators that produce the fault flags sit outside this block.

Top module: `hbridge_guard`

## Requirements
- R1: Each leg follows its own filtered commands. A filtered high-side command with no low-side command turns on that leg's high-side gate. A filtered low-side command with no high-side command turns on the low-side gate. Neither command turns both off. Legs are independent.
- R2: If a leg's high-side and low-side commands are both asserted, both gates of that leg are off. They stay off for as long as the conflict lasts.
- R3: A gate turns on only after both gates of its leg have been off for DEAD_CYC cycles. A command that starts from idle reaches its gate DEGLITCH_CYC+DEAD_CYC clock edges after the input changes. A dropped command turns its gate off DEGLITCH_CYC+1 edges after the input changes. In a direction swap, the new gate turns on DEAD_CYC edges after the old one turns off.
- R4: A command pulse shorter than DEGLITCH_CYC cycles has no effect on any gate. Such a pulse leaves no partial count behind.
- R5: If any one of the four overcurrent flags is high for OCP_CYC consecutive cycles, all gates go off. Flag bit 2*leg is the high side and bit 2*leg+1 is the low side. Status then reads 1 for exactly RETRY_CYC cycles, and after that the bridge re-arms. A flag held high for fewer than OCP_CYC cycles has no effect.
- R6: Over-temperature turns all gates off and reports status 2. The shutdown holds after the flag drops. It ends only when the cool-down flag is seen, provided over-temperature is low at that moment.
- R7: Undervoltage turns all gates off and reports status 3. It also clears all latched fault state: the thermal latch, the overcurrent latch and the counters. When the flag drops, status returns to 0 on the next cycle.
- R8: Overvoltage turns all gates off and reports status 4. Operation resumes as soon as the flag drops, with no retry delay.
- R9: While sleep_ni is low, all gates are off. The latched fault state is cleared.
- R10: Status encodings are 0 none, 1 overcurrent, 2 thermal, 3 undervoltage and 4 overvoltage. When faults are active together, the priority is undervoltage, then overvoltage, then thermal, then overcurrent.
- R11: All fault flags and sleep_ni are registered once before use. Status changes one edge after a flag changes, and gates turn off two edges after a flag rises. After a shutdown is released, gates stay off until the commands have been filtered again and the dead time has passed. This takes 1+DEGLITCH_CYC+DEAD_CYC edges after the flag drops for sleep, undervoltage or overvoltage. It takes 2+DEGLITCH_CYC+DEAD_CYC edges after the cool-down flag rises.
- R12: During reset all gates are off and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_ni | input | 1 | Low puts the bridge to sleep |
| cmd_hi_i | input | 2 | High-side command per leg |
| cmd_lo_i | input | 2 | Low-side command per leg |
| oc_i | input | 4 | Overcurrent flag per switch (bit 2*leg high, 2*leg+1 low) |
| ot_i | input | 1 | Over-temperature flag |
| ot_clr_i | input | 1 | Temperature below threshold minus hysteresis |
| uv_i | input | 1 | Undervoltage flag |
| ov_i | input | 1 | Overvoltage flag |
| gate_hi_o | output | 2 | High-side gate enable per leg |
| gate_lo_o | output | 2 | Low-side gate enable per leg |
| fault_o | output | 3 | Active fault code |

## Verification
The bench keeps the default filter length of 4 and dead time of 10. It shortens the overcurrent qualification to 6 cycles and the retry delay to 40 cycles. With those values, every overcurrent source can be tripped and its retry can run to completion within a short run. The bench sweeps all 16 command patterns and checks each output at the exact edge of the transition and one edge before it. It sweeps all 8 combinations of the undervoltage, overvoltage and thermal flags to check the priority order. It tries every pulse length below the filter length.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_OC    = 3'd1,
    FLT_THERM = 3'd2,
    FLT_UV    = 3'd3,
    FLT_OV    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;
endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
  parameter int WIDTH  = 4,
  parameter int STABLE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        bit_q <= 1'b0;
      end else if (clr_i) begin
        cnt_q <= '0;
        bit_q <= 1'b0;
      end else if (d_i[g] == bit_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        bit_q <= d_i[g];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign q_o[g] = bit_q;
  end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic gate_hi_o,
  output logic gate_lo_o
);
  localparam int CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] LAST = CW'(DEAD - 1);

  leg_e          want;
  leg_e          state_q;
  logic [CW-1:0] dead_q;

  // conflicting requests resolve to off
  always_comb begin
    if (hi_i && !lo_i)      want = LEG_HI;
    else if (lo_i && !hi_i) want = LEG_LO;
    else                    want = LEG_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LEG_OFF;
      dead_q  <= '0;
    end else if (halt_i) begin
      state_q <= LEG_OFF;
      dead_q  <= '0;
    end else if (state_q != LEG_OFF) begin
      if (want != state_q) begin
        state_q <= LEG_OFF;
        dead_q  <= '0;
      end
    end else if (want == LEG_OFF) begin
      dead_q <= '0;
    end else if (dead_q == LAST) begin
      state_q <= want;
    end else begin
      dead_q <= dead_q + 1'b1;
    end
  end

  assign gate_hi_o = (state_q == LEG_HI);
  assign gate_lo_o = (state_q == LEG_LO);
endmodule

// File: rtl/hb_fault_ctrl.sv
module hb_fault_ctrl
  import hb_pkg::*;
#(
  parameter int NSW   = 4,
  parameter int OCP   = 200,
  parameter int RETRY = 100000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sleep_ni,
  input  logic [NSW-1:0] oc_i,
  input  logic           ot_i,
  input  logic           ot_clr_i,
  input  logic           uv_i,
  input  logic           ov_i,
  output logic           halt_o,
  output fault_e         fault_o
);
  localparam int OW = $clog2(OCP + 1);
  localparam int RW = $clog2(RETRY + 1);
  localparam logic [OW-1:0] OC_LAST = OW'(OCP - 1);
  localparam logic [RW-1:0] RT_LAST = RW'(RETRY - 1);

  logic           awake_q, ot_q, otc_q, uv_q, ov_q;
  logic [NSW-1:0] oc_q;
  logic [NSW-1:0] oc_hit;
  logic           logic_rst, oc_trip;
  logic           oc_lat_q, ot_lat_q;
  logic [RW-1:0]  retry_q;

  // one register stage on the comparator flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awake_q <= 1'b0;
      oc_q    <= '0;
      ot_q    <= 1'b0;
      otc_q   <= 1'b0;
      uv_q    <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      awake_q <= sleep_ni;
      oc_q    <= oc_i;
      ot_q    <= ot_i;
      otc_q   <= ot_clr_i;
      uv_q    <= uv_i;
      ov_q    <= ov_i;
    end
  end

  assign logic_rst = uv_q || !awake_q;

  for (genvar g = 0; g < NSW; g++) begin : g_oc
    logic [OW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= '0;
      else if (logic_rst || oc_lat_q || !oc_q[g]) cnt_q <= '0;
      else if (cnt_q != OC_LAST)                cnt_q <= cnt_q + 1'b1;
    end
    assign oc_hit[g] = oc_q[g] && (cnt_q == OC_LAST);
  end

  assign oc_trip = (|oc_hit) && !oc_lat_q && !logic_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_lat_q <= 1'b0;
      retry_q  <= '0;
    end else if (logic_rst) begin
      oc_lat_q <= 1'b0;
      retry_q  <= '0;
    end else if (oc_trip) begin
      oc_lat_q <= 1'b1;
      retry_q  <= '0;
    end else if (oc_lat_q) begin
      if (retry_q == RT_LAST) oc_lat_q <= 1'b0;
      else                    retry_q  <= retry_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ot_lat_q <= 1'b0;
    else if (logic_rst) ot_lat_q <= 1'b0;
    else if (ot_q)      ot_lat_q <= 1'b1;
    else if (otc_q)     ot_lat_q <= 1'b0;
  end

  assign halt_o = logic_rst || ov_q || ot_q || ot_lat_q || oc_lat_q || oc_trip;

  always_comb begin
    if (uv_q)                   fault_o = FLT_UV;
    else if (ov_q)              fault_o = FLT_OV;
    else if (ot_q || ot_lat_q)  fault_o = FLT_THERM;
    else if (oc_lat_q)          fault_o = FLT_OC;
    else                        fault_o = FLT_NONE;
  end
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
  import hb_pkg::*;
#(
  parameter int LEGS         = 2,
  parameter int DEGLITCH_CYC = 4,
  parameter int DEAD_CYC     = 10,
  parameter int OCP_CYC      = 200,
  parameter int RETRY_CYC    = 100000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_ni,
  input  logic [LEGS-1:0] cmd_hi_i,
  input  logic [LEGS-1:0] cmd_lo_i,
  input  logic [2*LEGS-1:0] oc_i,
  input  logic            ot_i,
  input  logic            ot_clr_i,
  input  logic            uv_i,
  input  logic            ov_i,
  output logic [LEGS-1:0] gate_hi_o,
  output logic [LEGS-1:0] gate_lo_o,
  output logic [2:0]      fault_o
);
  localparam int NSW = 2 * LEGS;

  logic           halt;
  fault_e         flt;
  logic [NSW-1:0] cmd_f;

  hb_fault_ctrl #(
    .NSW  (NSW),
    .OCP  (OCP_CYC),
    .RETRY(RETRY_CYC)
  ) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_ni(sleep_ni),
    .oc_i    (oc_i),
    .ot_i    (ot_i),
    .ot_clr_i(ot_clr_i),
    .uv_i    (uv_i),
    .ov_i    (ov_i),
    .halt_o  (halt),
    .fault_o (flt)
  );

  // filters restart from zero after every shutdown
  hb_deglitch #(
    .WIDTH (NSW),
    .STABLE(DEGLITCH_CYC)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (halt),
    .d_i   ({cmd_lo_i, cmd_hi_i}),
    .q_o   (cmd_f)
  );

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    hb_leg #(
      .DEAD(DEAD_CYC)
    ) u_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .halt_i   (halt),
      .hi_i     (cmd_f[l]),
      .lo_i     (cmd_f[LEGS+l]),
      .gate_hi_o(gate_hi_o[l]),
      .gate_lo_o(gate_lo_o[l])
    );
  end

  assign fault_o = flt;
endmodule

// File: rtl/hbridge_guard_chk.sv
module hbridge_guard_chk #(
  parameter int LEGS     = 2,
  parameter int DEAD_CYC = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sleep_ni,
  input logic            uv_i,
  input logic            ov_i,
  input logic [LEGS-1:0] gate_hi_o,
  input logic [LEGS-1:0] gate_lo_o,
  input logic [2:0]      fault_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD = CW'(DEAD_CYC);

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic [CW-1:0] idle_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        idle_q <= '0;
      else if (gate_hi_o[g] || gate_lo_o[g]) idle_q <= '0;
      else if (idle_q != DEAD)            idle_q <= idle_q + 1'b1;
    end

    p_no_shoot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_hi_o[g] && gate_lo_o[g]));
    p_dead_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_hi_o[g]) |-> idle_q >= DEAD);
    p_dead_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_lo_o[g]) |-> idle_q >= DEAD);
  end

  p_uv_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_i, 2) |-> (gate_hi_o == '0 && gate_lo_o == '0));
  p_uv_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_i) |-> fault_o == 3'd3);
  p_ov_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ov_i, 2) |-> (gate_hi_o == '0 && gate_lo_o == '0));
  p_sleep_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sleep_ni, 2) |-> (gate_hi_o == '0 && gate_lo_o == '0));
  p_oc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == 3'd1) |-> (gate_hi_o == '0 && gate_lo_o == '0));
endmodule

bind hbridge_guard hbridge_guard_chk #(.LEGS(LEGS), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sleep_ni (sleep_ni),
  .uv_i     (uv_i),
  .ov_i     (ov_i),
  .gate_hi_o(gate_hi_o),
  .gate_lo_o(gate_lo_o),
  .fault_o  (fault_o)
);

// File: tb/hbridge_guard_tb.sv
module hbridge_guard_tb;
  localparam int DG     = 4;
  localparam int DEAD   = 10;
  localparam int OCP    = 6;
  localparam int RETRY  = 40;
  localparam int ON_LAT = DG + DEAD;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_n;
  logic [1:0] cmd_hi, cmd_lo;
  logic [3:0] oc;
  logic       ot, ot_clr, uv, ov;
  logic [1:0] gh, gl;
  logic [2:0] fault;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hbridge_guard #(
    .DEGLITCH_CYC(DG),
    .DEAD_CYC    (DEAD),
    .OCP_CYC     (OCP),
    .RETRY_CYC   (RETRY)
  ) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sleep_ni (sleep_n),
    .cmd_hi_i (cmd_hi),
    .cmd_lo_i (cmd_lo),
    .oc_i     (oc),
    .ot_i     (ot),
    .ot_clr_i (ot_clr),
    .uv_i     (uv),
    .ov_i     (ov),
    .gate_hi_o(gh),
    .gate_lo_o(gl),
    .fault_o  (fault)
  );

  wire [3:0] gates = {gl, gh};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_g(input logic [1:0] h, input logic [1:0] l);
    return {l & ~h, h & ~l};
  endfunction

  function automatic logic [2:0] exp_code(input logic u, input logic o, input logic t);
    if (u) return 3'd3;
    if (o) return 3'd4;
    if (t) return 3'd2;
    return 3'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b1; cmd_hi = '0; cmd_lo = '0;
    oc = '0; ot = 1'b0; ot_clr = 1'b0; uv = 1'b0; ov = 1'b0;
    tick(3);
    chk("R12 gates in reset", 32'(gates), 0);
    chk("R12 fault in reset", 32'(fault), 0);
    rst_n = 1'b1;
    tick(2);

    // R1 R2 R3: every command pattern
    for (int c = 0; c < 16; c++) begin
      logic [3:0] e;
      cmd_hi = c[1:0];
      cmd_lo = c[3:2];
      e = exp_g(c[1:0], c[3:2]);
      tick(ON_LAT - 1);
      chk("R3 still dead", 32'(gates), 0);
      tick(1);
      chk("R1 R2 pattern", 32'(gates), 32'(e));
      cmd_hi = '0; cmd_lo = '0;
      tick(DG);
      chk("R3 held before drop", 32'(gates), 32'(e));
      tick(1);
      chk("R3 dropped", 32'(gates), 0);
      tick(2);
    end

    // R4: short pulses ignored
    for (int len = 1; len < DG; len++) begin
      bit bad;
      bad = 1'b0;
      cmd_hi = 2'b01;
      tick(len);
      cmd_hi = 2'b00;
      repeat (ON_LAT + 2) begin
        tick(1);
        if (gates != 0) bad = 1'b1;
      end
      chk("R4 glitch ignored", 32'(bad), 0);
    end
    cmd_hi = 2'b01;
    tick(ON_LAT - 1);
    chk("R4 no residue early", 32'(gates), 0);
    tick(1);
    chk("R4 no residue on", 32'(gates), 4'b0001);

    // R3 direction swap on leg 0
    cmd_hi = 2'b00; cmd_lo = 2'b01;
    tick(DG);
    chk("R3 swap old held", 32'(gates), 4'b0001);
    tick(1);
    chk("R3 swap both off", 32'(gates), 0);
    tick(DEAD - 1);
    chk("R3 swap dead", 32'(gates), 0);
    tick(1);
    chk("R3 swap new on", 32'(gates), 4'b0100);

    // R2 conflict from running state
    cmd_hi = 2'b01;
    tick(DG);
    chk("R2 before conflict", 32'(gates), 4'b0100);
    tick(1);
    chk("R2 conflict off", 32'(gates), 0);
    tick(ON_LAT);
    chk("R2 conflict stays off", 32'(gates), 0);
    cmd_hi = '0; cmd_lo = '0;
    tick(DG + 2);

    cmd_hi = 2'b01; cmd_lo = 2'b10;
    tick(ON_LAT);
    chk("R1 both legs", 32'(gates), 4'b1001);

    // R9 sleep
    sleep_n = 1'b0;
    tick(1);
    chk("R11 sleep latency", 32'(gates), 4'b1001);
    tick(1);
    chk("R9 sleep off", 32'(gates), 0);
    tick(20);
    chk("R9 sleep held", 32'(gates), 0);
    chk("R9 sleep code", 32'(fault), 0);
    sleep_n = 1'b1;
    tick(ON_LAT);
    chk("R11 wake rearm", 32'(gates), 0);
    tick(1);
    chk("R11 wake on", 32'(gates), 4'b1001);

    // R7 undervoltage while running
    uv = 1'b1;
    tick(1);
    chk("R7 uv code", 32'(fault), 3);
    chk("R11 uv latency", 32'(gates), 4'b1001);
    tick(1);
    chk("R7 uv off", 32'(gates), 0);
    uv = 1'b0;
    tick(ON_LAT);
    chk("R11 uv rearm", 32'(gates), 0);
    tick(1);
    chk("R11 uv on", 32'(gates), 4'b1001);

    // R7 undervoltage clears thermal latch
    ot = 1'b1;
    tick(1);
    chk("R6 thermal code", 32'(fault), 2);
    ot = 1'b0;
    tick(2);
    chk("R6 thermal off", 32'(gates), 0);
    uv = 1'b1;
    tick(5);
    chk("R10 uv over thermal", 32'(fault), 3);
    uv = 1'b0;
    tick(1);
    chk("R7 latch cleared", 32'(fault), 0);
    tick(ON_LAT - 1);
    chk("R7 rearm", 32'(gates), 0);
    tick(1);
    chk("R7 on", 32'(gates), 4'b1001);

    // R8 overvoltage
    ov = 1'b1;
    tick(1);
    chk("R8 ov code", 32'(fault), 4);
    tick(1);
    chk("R8 ov off", 32'(gates), 0);
    tick(30);
    ov = 1'b0;
    tick(1);
    chk("R8 ov cleared", 32'(fault), 0);
    tick(ON_LAT - 1);
    chk("R8 rearm", 32'(gates), 0);
    tick(1);
    chk("R8 resume", 32'(gates), 4'b1001);

    // R6 thermal hysteresis
    ot = 1'b1;
    tick(2);
    chk("R6 off", 32'(gates), 0);
    ot = 1'b0;
    tick(50);
    chk("R6 hold gates", 32'(gates), 0);
    chk("R6 hold code", 32'(fault), 2);
    ot_clr = 1'b1;
    tick(1);
    chk("R6 clr pending", 32'(fault), 2);
    tick(1);
    chk("R6 cleared", 32'(fault), 0);
    ot_clr = 1'b0;
    tick(ON_LAT - 1);
    chk("R11 thermal rearm", 32'(gates), 0);
    tick(1);
    chk("R6 resume", 32'(gates), 4'b1001);

    // R5 short overcurrent ignored
    oc = 4'b0001;
    tick(OCP - 1);
    oc = '0;
    tick(5);
    chk("R5 short oc code", 32'(fault), 0);
    chk("R5 short oc gates", 32'(gates), 4'b1001);

    // R5 trip and retry on each switch
    for (int s = 0; s < 4; s++) begin
      oc = 4'(1 << s);
      tick(OCP);
      chk("R5 before trip", 32'(gates), 4'b1001);
      chk("R5 before trip code", 32'(fault), 0);
      tick(1);
      chk("R5 trip off", 32'(gates), 0);
      chk("R5 trip code", 32'(fault), 1);
      oc = '0;
      tick(RETRY - 1);
      chk("R5 retry hold", 32'(fault), 1);
      tick(1);
      chk("R5 retry end", 32'(fault), 0);
      tick(ON_LAT - 1);
      chk("R5 rearm", 32'(gates), 0);
      tick(1);
      chk("R5 resume", 32'(gates), 4'b1001);
    end

    // R10 priority sweep
    for (int c = 0; c < 8; c++) begin
      uv = c[0]; ov = c[1]; ot = c[2];
      tick(1);
      chk("R10 priority", 32'(fault), 32'(exp_code(c[0], c[1], c[2])));
      uv = 1'b0; ov = 1'b0; ot = 1'b0;
      ot_clr = 1'b1;
      tick(2);
      ot_clr = 1'b0;
      tick(1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule